// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block sits between a host register port and a card link. A 16-bit command word written by the host is split into fields. The block sends the command index with a 32-bit argument to the card as a one-cycle request. It then gathers the response bytes the card returns until the card signals the end of the response. Once the response is complete, the block judges it against the response type. It marks a response that is too short as a timeout, tests the card status bits against an error mask for that type, applies the busy flag of the operating-conditions response, and loads eight 16-bit response registers.

The host also sees a status register whose bits are cleared by writing ones. An enable mask of 15 bits picks which status bits raise the single interrupt line. The command path is a four-state machine:
- `ST_IDLE` waits for an accepted command write. The go transition leads to `ST_ISSUE`. An init/index-0 write is the shortcut transition, which stays in `ST_IDLE`.
- `ST_ISSUE` drives the card request for one cycle and always moves to `ST_COLLECT`.
- `ST_COLLECT` stores arriving bytes. On the card's done strobe it moves to `ST_EVAL`.
- `ST_EVAL` updates status and response registers in one cycle and returns to `ST_IDLE`.

Host register selects on `reg_wr_sel` are: 0 command, 1 argument low half, 2 argument high half, 3 control (bit 0 = enable), 4 status clear, 5 interrupt mask.

Top module: `sdc_cmd_host`

## Requirements
- R1: A command write is accepted only when the enable is set and the block is idle. The command word carries the index in bits 5:0, the init flag in bit 7, the response type in bits 10:8 and busy in bit 11; bits 15:12 are not decoded. An accepted write raises `card_req_o` for exactly one cycle, with the index on `card_idx_o` and the argument on `card_arg_o`, and `busy_o` is high from the request until the status update.
- R2: A command write is ignored, with no request, no state change and no status change, while the enable (control bit 0) is clear or while a command is still in flight.
- R3: A command write with the init flag set and index 0 only sets status bit 0, issues no request and leaves the block idle.
- R4: Response type codes 1, 3 and 6 need at least 4 bytes, and code 2 needs 16. Fewer bytes set timeout status bit 7 instead of bit 0. Busy (bit 11) does not change the type-1 rules. Code 0 and the unlisted codes check no length and store nothing.
- R5: For type 3 without timeout, status bit 12 is set when bit 31 of the first four bytes (MSB of byte 0) is clear, and cleared when it is set.
- R6: Status bit 14 is set when the card status is nonzero under the type's error mask, and cleared otherwise. Type 1 tests bytes 0..3 taken big-endian against 0xFDF90000. Type 6 tests bytes 2..3 against 0xE008. Other types, and any timeout, clear it.
- R7: Response register 7−i holds byte 2i in its high half and byte 2i+1 in its low half. All registers are zeroed on every accepted command write, are loaded only for a length-checked type without timeout, and bytes past the sixteenth are dropped.
- R8: Completion without timeout sets status bit 0. When the index is 12 it also sets status bit 2.
- R9: Writing ones to the status register clears those bits, and zeros leave bits unchanged.
- R10: The mask holds bits 14:0 of the written value. `irq_o` is high exactly when status AND mask is nonzero.
- R11: The argument is written as two 16-bit halves, and each write replaces only its own half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_wr_sel | input | 3 | Host register select |
| reg_wr_data | input | 16 | Host write data |
| rsp_rd_sel | input | 3 | Response register index to read |
| rsp_rd_data | output | 16 | Selected response register |
| status_o | output | 16 | Status register |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Command in flight |
| card_req_o | output | 1 | One-cycle command request to the card |
| card_idx_o | output | 6 | Command index to the card |
| card_arg_o | output | 32 | Command argument to the card |
| card_byte_valid_i | input | 1 | Response byte valid |
| card_byte_i | input | 8 | Response byte |
| card_done_i | input | 1 | End of response |

## Verification
The bench builds the block with the default of eight response registers, so a full 16-byte long response fills every register. With that size, an 18-byte response reaches the drop of surplus bytes. The same size also puts a long response that stops at eight bytes within reach, showing the timeout path beside a partly filled buffer. A small card model in the bench answers each request with chosen byte strings, including an empty one and a three-byte short one.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_COLLECT, ST_EVAL} sdc_state_e;

    localparam logic [2:0] RT_NONE  = 3'd0;
    localparam logic [2:0] RT_SHORT = 3'd1;
    localparam logic [2:0] RT_LONG  = 3'd2;
    localparam logic [2:0] RT_OCR   = 3'd3;
    localparam logic [2:0] RT_RCA   = 3'd6;

    localparam logic [2:0] SEL_CMD    = 3'd0;
    localparam logic [2:0] SEL_ARG_LO = 3'd1;
    localparam logic [2:0] SEL_ARG_HI = 3'd2;
    localparam logic [2:0] SEL_CTRL   = 3'd3;
    localparam logic [2:0] SEL_STAT   = 3'd4;
    localparam logic [2:0] SEL_MASK   = 3'd5;

    localparam logic [31:0] SHORT_ERR_MASK = 32'hFDF9_0000;
    localparam logic [15:0] RCA_ERR_MASK   = 16'hE008;

    localparam int SB_DONE  = 0;
    localparam int SB_STOP  = 2;
    localparam int SB_TMO   = 7;
    localparam int SB_CBUSY = 12;
    localparam int SB_CERR  = 14;
endpackage

// File: rtl/sdc_rsp_store.sv
module sdc_rsp_store #(
    parameter  int RSP_REGS  = 8,
    localparam int RSP_BYTES = 2 * RSP_REGS,
    localparam int CW        = $clog2(RSP_BYTES + 1),
    localparam int SW        = $clog2(RSP_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          byte_we_i,
    input  logic [7:0]    byte_i,
    input  logic          commit_i,
    input  logic [SW-1:0] rd_sel_i,
    output logic [15:0]   rd_data_o,
    output logic [31:0]   head_word_o,
    output logic [CW-1:0] byte_cnt_o
);
    logic [7:0]    byte_q [RSP_BYTES];
    logic [15:0]   rsp_q  [RSP_REGS];
    logic [CW-1:0] cnt_q;
    logic          room;

    assign room = cnt_q < CW'(RSP_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int b = 0; b < RSP_BYTES; b++) byte_q[b] <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
            for (int b = 0; b < RSP_BYTES; b++) byte_q[b] <= '0;
        end else if (byte_we_i && room) begin
            cnt_q <= cnt_q + 1'b1;
            for (int b = 0; b < RSP_BYTES; b++)
                if (cnt_q == CW'(b)) byte_q[b] <= byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < RSP_REGS; r++) rsp_q[r] <= '0;
        end else if (clear_i) begin
            for (int r = 0; r < RSP_REGS; r++) rsp_q[r] <= '0;
        end else if (commit_i) begin
            for (int r = 0; r < RSP_REGS; r++)
                rsp_q[RSP_REGS-1-r] <= {byte_q[2*r], byte_q[2*r+1]};
        end
    end

    assign rd_data_o   = rsp_q[rd_sel_i];
    assign head_word_o = {byte_q[0], byte_q[1], byte_q[2], byte_q[3]};
    assign byte_cnt_o  = cnt_q;

    // R7: surplus bytes never push the count past the buffer size
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == CW'(RSP_BYTES) && byte_we_i && !clear_i |=> cnt_q == CW'(RSP_BYTES));
endmodule

// File: rtl/sdc_status_irq.sv
module sdc_status_irq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_we_i,
    input  logic [15:0] clr_data_i,
    input  logic        ev_valid_i,
    input  logic [15:0] ev_set_i,
    input  logic [15:0] ev_upd_mask_i,
    input  logic [15:0] ev_upd_val_i,
    input  logic        mask_we_i,
    input  logic [14:0] mask_data_i,
    output logic [15:0] status_o,
    output logic        irq_o
);
    logic [15:0] status_q;
    logic [14:0] mask_q;
    logic [15:0] after_clr;

    always_comb begin
        after_clr = clr_we_i ? (status_q & ~clr_data_i) : status_q;
        if (ev_valid_i)
            after_clr = (after_clr & ~ev_upd_mask_i) | (ev_upd_val_i & ev_upd_mask_i) | ev_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= after_clr;
            if (mask_we_i) mask_q <= mask_data_i;
        end
    end

    assign status_o = status_q;
    assign irq_o    = |(status_q[14:0] & mask_q);

    // R9: a clear with no event in the same cycle removes every written one
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i && !ev_valid_i |=> (status_q & $past(clr_data_i)) == 16'h0);
    // R10: with no interrupt, no unmasked status bit is set
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (status_o[14:0] & mask_q) == 15'h0);
endmodule

// File: rtl/sdc_cmd_fsm.sv
module sdc_cmd_fsm
    import sdc_pkg::*;
#(
    parameter  int RSP_BYTES = 16,
    localparam int CW        = $clog2(RSP_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [5:0]    idx_i,
    input  logic [2:0]    rtype_i,
    input  logic          init_i,
    input  logic          byte_valid_i,
    input  logic          done_i,
    input  logic [CW-1:0] byte_cnt_i,
    input  logic [31:0]   head_word_i,
    output logic          busy_o,
    output logic          card_req_o,
    output logic [5:0]    card_idx_o,
    output logic          byte_we_o,
    output logic          commit_o,
    output logic          ev_valid_o,
    output logic [15:0]   ev_set_o,
    output logic [15:0]   ev_upd_mask_o,
    output logic [15:0]   ev_upd_val_o
);
    sdc_state_e    state_q, state_d;
    logic [5:0]    idx_q;
    logic [2:0]    rtype_q;
    logic          shortcut;
    logic [CW-1:0] need_len;
    logic          checked, tmo, err;
    logic [31:0]   rstat, emask;

    assign shortcut = go_i && init_i && (idx_i == 6'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rtype_q <= RT_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && go_i && !shortcut) begin
                idx_q   <= idx_i;
                rtype_q <= rtype_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go_i && !shortcut) state_d = ST_ISSUE;
            ST_ISSUE:   state_d = ST_COLLECT;
            ST_COLLECT: if (done_i) state_d = ST_EVAL;
            ST_EVAL:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        need_len = '0;
        rstat    = '0;
        emask    = '0;
        case (rtype_q)
            RT_SHORT: begin need_len = CW'(4); rstat = head_word_i; emask = SHORT_ERR_MASK; end
            RT_OCR:   begin need_len = CW'(4); rstat = head_word_i; end
            RT_RCA:   begin need_len = CW'(4); rstat = {16'h0, head_word_i[15:0]};
                            emask = {16'h0, RCA_ERR_MASK}; end
            RT_LONG:  need_len = CW'(RSP_BYTES);
            default:  need_len = '0;
        endcase
        checked = need_len != '0;
        tmo     = byte_cnt_i < need_len;
        err     = !tmo && ((rstat & emask) != 32'h0);
    end

    always_comb begin
        busy_o        = state_q != ST_IDLE;
        card_req_o    = state_q == ST_ISSUE;
        card_idx_o    = idx_q;
        byte_we_o     = (state_q == ST_COLLECT) && byte_valid_i;
        commit_o      = 1'b0;
        ev_valid_o    = 1'b0;
        ev_set_o      = '0;
        ev_upd_mask_o = '0;
        ev_upd_val_o  = '0;
        unique case (state_q)
            ST_IDLE: if (shortcut) begin
                ev_valid_o         = 1'b1;
                ev_set_o[SB_DONE]  = 1'b1;
            end
            ST_EVAL: begin
                ev_valid_o             = 1'b1;
                commit_o               = checked && !tmo;
                ev_upd_mask_o[SB_CERR] = 1'b1;
                ev_upd_val_o[SB_CERR]  = err;
                if (rtype_q == RT_OCR && !tmo) begin
                    ev_upd_mask_o[SB_CBUSY] = 1'b1;
                    ev_upd_val_o[SB_CBUSY]  = !head_word_i[31];
                end
                if (tmo) ev_set_o[SB_TMO] = 1'b1;
                else begin
                    ev_set_o[SB_DONE] = 1'b1;
                    ev_set_o[SB_STOP] = idx_q == 6'd12;
                end
            end
            default: ;
        endcase
    end

    // R1: the card request lasts a single cycle
    p_req_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        card_req_o |=> !card_req_o);
    // R1: evaluation always hands back to idle
    p_eval_return_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EVAL |=> state_q == ST_IDLE);
    // R7: registers are loaded only after at least four bytes arrived
    p_commit_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> byte_cnt_i >= CW'(4));
    // R3: the shortcut never starts a request
    p_init_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shortcut && state_q == ST_IDLE |=> !card_req_o && !busy_o);
endmodule

// File: rtl/sdc_cmd_host.sv
module sdc_cmd_host
    import sdc_pkg::*;
#(
    parameter  int RSP_REGS  = 8,
    localparam int RSP_BYTES = 2 * RSP_REGS,
    localparam int CW        = $clog2(RSP_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_wr_sel,
    input  logic [15:0] reg_wr_data,
    input  logic [2:0]  rsp_rd_sel,
    output logic [15:0] rsp_rd_data,
    output logic [15:0] status_o,
    output logic        irq_o,
    output logic        busy_o,
    output logic        card_req_o,
    output logic [5:0]  card_idx_o,
    output logic [31:0] card_arg_o,
    input  logic        card_byte_valid_i,
    input  logic [7:0]  card_byte_i,
    input  logic        card_done_i
);
    logic [31:0]   arg_q;
    logic          en_q;
    logic          go, byte_we, commit;
    logic          ev_valid;
    logic [15:0]   ev_set, ev_upd_mask, ev_upd_val;
    logic [31:0]   head_word;
    logic [CW-1:0] byte_cnt;

    assign go = reg_wr_en && reg_wr_sel == SEL_CMD && en_q && !busy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q <= '0;
            en_q  <= 1'b0;
        end else if (reg_wr_en) begin
            if (reg_wr_sel == SEL_ARG_LO) arg_q[15:0]  <= reg_wr_data;
            if (reg_wr_sel == SEL_ARG_HI) arg_q[31:16] <= reg_wr_data;
            if (reg_wr_sel == SEL_CTRL)   en_q         <= reg_wr_data[0];
        end
    end

    assign card_arg_o = arg_q;

    sdc_cmd_fsm #(.RSP_BYTES(RSP_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go_i(go),
        .idx_i(reg_wr_data[5:0]), .rtype_i(reg_wr_data[10:8]), .init_i(reg_wr_data[7]),
        .byte_valid_i(card_byte_valid_i), .done_i(card_done_i),
        .byte_cnt_i(byte_cnt), .head_word_i(head_word),
        .busy_o(busy_o), .card_req_o(card_req_o), .card_idx_o(card_idx_o),
        .byte_we_o(byte_we), .commit_o(commit), .ev_valid_o(ev_valid),
        .ev_set_o(ev_set), .ev_upd_mask_o(ev_upd_mask), .ev_upd_val_o(ev_upd_val)
    );

    sdc_rsp_store #(.RSP_REGS(RSP_REGS)) u_store (
        .clk(clk), .rst_n(rst_n), .clear_i(go), .byte_we_i(byte_we),
        .byte_i(card_byte_i), .commit_i(commit), .rd_sel_i(rsp_rd_sel),
        .rd_data_o(rsp_rd_data), .head_word_o(head_word), .byte_cnt_o(byte_cnt)
    );

    sdc_status_irq u_stat (
        .clk(clk), .rst_n(rst_n),
        .clr_we_i(reg_wr_en && reg_wr_sel == SEL_STAT), .clr_data_i(reg_wr_data),
        .ev_valid_i(ev_valid), .ev_set_i(ev_set),
        .ev_upd_mask_i(ev_upd_mask), .ev_upd_val_i(ev_upd_val),
        .mask_we_i(reg_wr_en && reg_wr_sel == SEL_MASK), .mask_data_i(reg_wr_data[14:0]),
        .status_o(status_o), .irq_o(irq_o)
    );

    // R2: a command write while disabled and idle leaves the block idle
    p_cmd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && reg_wr_sel == SEL_CMD && !en_q && !busy_o |=> !busy_o);
    // R2: a command write in flight does not alter the issued index
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && reg_wr_en && reg_wr_sel == SEL_CMD |=> $stable(card_idx_o));
endmodule

// File: tb/test_sdc_cmd_host.sv
`timescale 1ns/100ps
module test_sdc_cmd_host;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [15:0] reg_wr_data = '0;
    logic [2:0]  rsp_rd_sel = '0;
    logic [15:0] rsp_rd_data, status_o;
    logic        irq_o, busy_o, card_req_o;
    logic [5:0]  card_idx_o;
    logic [31:0] card_arg_o;
    logic        card_byte_valid_i = 1'b0;
    logic [7:0]  card_byte_i = '0;
    logic        card_done_i = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] rb [20];

    always #2.5 clk = ~clk;

    sdc_cmd_host i_sdc_cmd_host (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [15:0] mk(input int idx, input int rt, input bit bsy, input bit init);
        return 16'((bsy << 11) | (rt << 8) | (init << 7) | idx);
    endfunction

    task automatic rd(input int sel, output logic [15:0] v);
        rsp_rd_sel = 3'(sel);
        #0.5;
        v = rsp_rd_data;
    endtask

    task automatic set4(input logic [7:0] a, b, c, d);
        rb[0] = a; rb[1] = b; rb[2] = c; rb[3] = d;
    endtask

    // issue a command and answer with n bytes from rb
    task automatic run_cmd(input logic [15:0] cmd, input int n);
        wr(3'd0, cmd);
        chk("R1 request raised", 32'(card_req_o), 32'd1);
        chk("R1 index", 32'(card_idx_o), 32'(cmd[5:0]));
        @(negedge clk);
        chk("R1 request single cycle", 32'(card_req_o), 32'd0);
        for (int k = 0; k < n; k++) begin
            card_byte_valid_i = 1'b1; card_byte_i = rb[k];
            @(negedge clk);
        end
        card_byte_valid_i = 1'b0;
        card_done_i = 1'b1;
        @(negedge clk);
        card_done_i = 1'b0;
        chk("R1 busy during eval", 32'(busy_o), 32'd1);
        @(negedge clk);
        chk("R1 idle after eval", 32'(busy_o), 32'd0);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(7, v);
        chk("R7 reset regs", 32'(v), 32'd0);
        chk("R9 reset status", 32'(status_o), 32'd0);
        chk("R10 reset irq", 32'(irq_o), 32'd0);
        chk("R1 reset busy", 32'(busy_o), 32'd0);
    endtask

    task automatic t_disabled();
        int seen = 0;
        wr(3'd0, mk(17, 1, 0, 0));
        for (int k = 0; k < 3; k++) begin
            if (card_req_o || busy_o) seen++;
            @(negedge clk);
        end
        chk("R2 disabled no request", 32'(seen), 32'd0);
        chk("R2 disabled status", 32'(status_o), 32'd0);
    endtask

    task automatic t_arg();
        wr(3'd3, 16'h0001);
        wr(3'd1, 16'h1234);
        wr(3'd2, 16'hABCD);
        wr(3'd1, 16'h5678);
        chk("R11 argument halves", card_arg_o, 32'hABCD5678);
    endtask

    task automatic t_short_ok();
        logic [15:0] v;
        set4(8'h00, 8'h00, 8'h09, 8'h00);
        run_cmd(mk(17, 1, 0, 0), 4);
        chk("R8 short ok status", 32'(status_o), 32'h0001);
        rd(6, v); chk("R7 reg6", 32'(v), 32'h0900);
        rd(7, v); chk("R7 reg7", 32'(v), 32'h0000);
        chk("R11 arg on card", card_arg_o, 32'hABCD5678);
    endtask

    task automatic t_short_err();
        set4(8'h80, 8'h00, 8'h00, 8'h00);
        run_cmd(mk(8, 1, 1, 0), 4);
        chk("R6 R4 short busy err", 32'(status_o), 32'h4001);
    endtask

    task automatic t_long();
        logic [15:0] v;
        for (int k = 0; k < 18; k++) rb[k] = 8'(8'h10 + k);
        run_cmd(mk(2, 2, 0, 0), 18);
        chk("R6 long clears err", 32'(status_o), 32'h0001);
        rd(7, v); chk("R7 long reg7", 32'(v), 32'h1011);
        rd(3, v); chk("R7 long reg3", 32'(v), 32'h1819);
        rd(0, v); chk("R7 long reg0 drops extra", 32'(v), 32'h1E1F);
    endtask

    task automatic t_timeout();
        logic [15:0] v;
        wr(3'd4, 16'hFFFF);
        for (int k = 0; k < 8; k++) rb[k] = 8'h55;
        run_cmd(mk(9, 2, 0, 0), 8);
        chk("R4 long timeout", 32'(status_o), 32'h0080);
        rd(7, v); chk("R7 no store on timeout", 32'(v), 32'h0000);
        wr(3'd4, 16'hFFFF);
        set4(8'h00, 8'h00, 8'h09, 8'h00);
        run_cmd(mk(13, 1, 0, 0), 3);
        chk("R4 short timeout", 32'(status_o), 32'h0080);
    endtask

    task automatic t_ocr();
        wr(3'd4, 16'hFFFF);
        set4(8'h00, 8'hFF, 8'h80, 8'h00);
        run_cmd(mk(41, 3, 0, 0), 4);
        chk("R5 ocr busy set", 32'(status_o), 32'h1001);
        set4(8'h80, 8'hFF, 8'h80, 8'h00);
        run_cmd(mk(41, 3, 0, 0), 4);
        chk("R5 ocr busy cleared", 32'(status_o), 32'h0001);
    endtask

    task automatic t_rca();
        set4(8'h00, 8'h00, 8'h20, 8'h00);
        run_cmd(mk(3, 6, 0, 0), 4);
        chk("R6 rca err", 32'(status_o), 32'h4001);
        set4(8'hAA, 8'hBB, 8'h00, 8'h00);
        run_cmd(mk(3, 6, 0, 0), 4);
        chk("R6 rca upper ignored", 32'(status_o), 32'h0001);
        set4(8'h00, 8'h00, 8'h00, 8'h08);
        run_cmd(mk(3, 6, 0, 0), 4);
        chk("R6 rca bit3", 32'(status_o), 32'h4001);
    endtask

    task automatic t_stop();
        wr(3'd4, 16'hFFFF);
        set4(8'h00, 8'h00, 8'h09, 8'h00);
        run_cmd(mk(12, 1, 0, 0), 4);
        chk("R8 index 12", 32'(status_o), 32'h0005);
    endtask

    task automatic t_w1c();
        wr(3'd4, 16'h0004);
        chk("R9 clear one bit", 32'(status_o), 32'h0001);
        wr(3'd4, 16'h0000);
        chk("R9 zero write no effect", 32'(status_o), 32'h0001);
    endtask

    task automatic t_irq();
        wr(3'd5, 16'h8004);
        chk("R10 unmasked quiet", 32'(irq_o), 32'd0);
        wr(3'd5, 16'h0001);
        chk("R10 masked raises", 32'(irq_o), 32'd1);
        wr(3'd4, 16'hFFFF);
        chk("R10 cleared drops", 32'(irq_o), 32'd0);
    endtask

    task automatic t_init();
        logic [15:0] v;
        set4(8'h00, 8'h00, 8'h09, 8'h00);
        run_cmd(mk(17, 1, 0, 0), 4);
        wr(3'd4, 16'hFFFF);
        wr(3'd0, mk(0, 1, 0, 1));
        chk("R3 init no request", 32'(card_req_o), 32'd0);
        chk("R3 init idle", 32'(busy_o), 32'd0);
        chk("R3 init status", 32'(status_o), 32'h0001);
        rd(6, v); chk("R7 regs zeroed by write", 32'(v), 32'h0000);
    endtask

    task automatic t_none();
        logic [15:0] v;
        wr(3'd4, 16'hFFFF);
        run_cmd(mk(5, 0, 0, 0), 0);
        chk("R4 no response no length", 32'(status_o), 32'h0001);
        set4(8'h11, 8'h22, 8'h33, 8'h44);
        run_cmd(mk(5, 0, 0, 0), 4);
        rd(7, v); chk("R4 no response not stored", 32'(v), 32'h0000);
    endtask

    task automatic t_busy_ignore();
        int seen = 0;
        wr(3'd4, 16'hFFFF);
        wr(3'd0, mk(20, 1, 0, 0));
        @(negedge clk);
        wr(3'd0, mk(33, 1, 0, 0));
        chk("R2 busy index kept", 32'(card_idx_o), 32'd20);
        card_done_i = 1'b1;
        @(negedge clk);
        card_done_i = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            if (card_req_o) seen++;
            @(negedge clk);
        end
        chk("R2 busy write no second request", 32'(seen), 32'd0);
        chk("R2 busy status timeout only", 32'(status_o), 32'h0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_arg();
        t_short_ok();
        t_short_err();
        t_long();
        t_timeout();
        t_ocr();
        t_rca();
        t_stop();
        t_w1c();
        t_irq();
        t_init();
        t_none();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule